// File: doc/BRIEF.md
# UART Receive Byte Queue with Trigger Level and Idle Timeout

This block is the receive-side holding queue of a UART. Bytes delivered by the deserializer are stored in a 16-deep first-in first-out buffer and removed one at a time when software reads the data register. The block reports the queue state as flags (empty, full, and at or above a software-set trigger level) and as an occupancy count. It also sends two single-cycle events to the interrupt unit: one when a byte is lost because the queue is full, and one when no byte has arrived for four character times.

Every access is gated by the receiver enable level. A synchronous clear empties the queue. The trigger level sits in a small register that resets to 32, above the queue depth, so the trigger flag stays low until software programs a lower level. The idle timeout is driven by a two-state machine. IDLE waits for a byte; the transition IDLE to RUN loads four times the character time. RUN counts down. A new byte gives the transition RUN to RUN, which reloads the count. When the count expires, the transition RUN to IDLE emits the timeout event.

Top module: `uart_rx_queue`

## Requirements
- R1: After reset, count is 0, empty is 1, full, trig_hit, overrun_evt and timeout_evt are 0, rd_data is 0, and the trigger level register holds 32.
- R2: When rx_enable is 0, wr_en and rd_en have no effect: the count, flags and rd_data hold their values.
- R3: When wr_en arrives while count is 16 and rx_enable is 1, the byte is dropped, the count stays at 16, and overrun_evt is high for exactly the following cycle.
- R4: Each accepted write raises the count by one. full is 1 exactly when count is 16. empty is 1 exactly when count is 0.
- R5: Reads return bytes in the order they were written. rd_data is updated in the cycle after the clock edge that samples rd_en, and otherwise holds its value.
- R6: A read while the queue is empty sets rd_data to 0 and leaves the count at 0.
- R7: After a clock edge that samples rx_enable and wr_en both high, timeout_evt is high for one cycle exactly 4*char_time edges later (or 1 edge later when char_time is 0), provided no further byte arrives. A new byte restarts the wait, and after the event the timer stays idle.
- R8: trig_hit is 1 exactly when count is at least the trigger level register. A one-cycle lvl_wr pulse loads lvl_data into that register.
- R9: fifo_clr empties the queue (count 0, empty 1, full 0) and takes priority over a write or read in the same cycle.
- R10: A write and a read in the same cycle are both served. If the queue was empty, the read returns 0 and the byte is stored. If the queue was full, the byte is dropped with an overrun event and the oldest byte is read out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_enable | input | 1 | Receiver enable level; gates writes and reads |
| fifo_clr | input | 1 | Synchronous queue clear |
| wr_en | input | 1 | Received byte strobe |
| wr_data | input | 8 | Received byte |
| rd_en | input | 1 | Data register read strobe |
| lvl_wr | input | 1 | Load strobe for the trigger level register |
| lvl_data | input | 6 | New trigger level |
| char_time | input | 16 | Clock cycles per character |
| rd_data | output | 8 | Byte from the last read (0 if the queue was empty) |
| empty | output | 1 | Queue holds no bytes |
| full | output | 1 | Queue holds 16 bytes |
| trig_hit | output | 1 | Count is at or above the trigger level |
| count | output | 5 | Current occupancy |
| overrun_evt | output | 1 | One-cycle pulse: a byte was dropped |
| timeout_evt | output | 1 | One-cycle pulse: idle for four character times |

## Verification
Three things can coincide in one cycle: a received byte, a data-register read, and sometimes a clear. The bench drives a write and a read together at each boundary: on an empty queue (the read returns 0 and the byte is kept), on a full queue (an overrun plus a pop), and mid-fill (the count is unchanged). It also asserts a clear together with both strobes. Every outcome is compared against a queue model kept in the bench, which serves the read from the pre-cycle state before it applies the write.

// File: rtl/uart_rx_queue_pkg.sv
package uart_rx_queue_pkg;
    typedef enum logic [0:0] {
        TMR_IDLE = 1'b0,
        TMR_RUN  = 1'b1
    } tmr_state_t;
endpackage

// File: rtl/rxq_storage.sv
// Circular byte store with registered read port; DEPTH must be a power of two.
module rxq_storage #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    input  logic              rd_zero,
    output logic [DATA_W-1:0] rd_data
);
    localparam int AW = $clog2(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wptr_q;
    logic [AW-1:0]     rptr_q;
    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wptr_q] <= push_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr_q  <= '0;
            rptr_q  <= '0;
            rdata_q <= '0;
        end else if (clr) begin
            wptr_q <= '0;
            rptr_q <= '0;
        end else begin
            if (push) begin
                wptr_q <= wptr_q + AW'(1);
            end
            if (pop) begin
                rptr_q  <= rptr_q + AW'(1);
                rdata_q <= mem[rptr_q];
            end else if (rd_zero) begin
                rdata_q <= '0;
            end
        end
    end

    assign rd_data = rdata_q;
endmodule

// File: rtl/rxq_idle_timer.sv
module rxq_idle_timer
    import uart_rx_queue_pkg::*;
#(
    parameter int TIME_W = 16,
    parameter int MULT   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic [TIME_W-1:0] char_time,
    output logic              fire
);
    localparam int CW = TIME_W + $clog2(MULT) + 1;

    tmr_state_t    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [CW-1:0] load_val;
    logic          fire_d, fire_q;

    always_comb begin
        load_val = CW'(char_time) * CW'(MULT);
        if (load_val == '0) begin
            load_val = CW'(1);
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        fire_d  = 1'b0;
        unique case (state_q)
            TMR_IDLE: begin
                if (restart) begin
                    state_d = TMR_RUN;
                    cnt_d   = load_val;
                end
            end
            TMR_RUN: begin
                if (restart) begin
                    cnt_d = load_val;
                end else if (cnt_q == CW'(1)) begin
                    state_d = TMR_IDLE;
                    fire_d  = 1'b1;
                end else begin
                    cnt_d = cnt_q - CW'(1);
                end
            end
            default: state_d = TMR_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TMR_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fire_q <= 1'b0;
        end else begin
            fire_q <= fire_d;
        end
    end

    assign fire = fire_q;
endmodule

// File: rtl/uart_rx_queue.sv
module uart_rx_queue #(
    parameter int DATA_W    = 8,
    parameter int DEPTH     = 16,
    parameter int LVL_W     = 6,
    parameter int LVL_RESET = 32,
    parameter int TIME_W    = 16,
    parameter int TMO_CHARS = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         rx_enable,
    input  logic                         fifo_clr,
    input  logic                         wr_en,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic                         rd_en,
    input  logic                         lvl_wr,
    input  logic [LVL_W-1:0]             lvl_data,
    input  logic [TIME_W-1:0]            char_time,
    output logic [DATA_W-1:0]            rd_data,
    output logic                         empty,
    output logic                         full,
    output logic                         trig_hit,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         overrun_evt,
    output logic                         timeout_evt
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int CMP_W = (CNT_W > LVL_W) ? CNT_W : LVL_W;

    logic [CNT_W-1:0] cnt_q;
    logic [LVL_W-1:0] lvl_q;
    logic             ovr_q;
    logic             is_empty, is_full;
    logic             rd_req, wr_req;
    logic             do_push, do_pop, do_zero, do_ovr;
    logic             byte_seen;

    assign is_empty  = (cnt_q == '0);
    assign is_full   = (cnt_q == CNT_W'(DEPTH));
    assign rd_req    = !fifo_clr && rx_enable && rd_en;
    assign wr_req    = !fifo_clr && rx_enable && wr_en;
    assign do_pop    = rd_req && !is_empty;
    assign do_zero   = rd_req && is_empty;
    assign do_push   = wr_req && !is_full;
    assign do_ovr    = wr_req && is_full;
    assign byte_seen = rx_enable && wr_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ovr_q <= 1'b0;
        end else begin
            ovr_q <= do_ovr;
            if (fifo_clr) begin
                cnt_q <= '0;
            end else if (do_push && !do_pop) begin
                cnt_q <= cnt_q + CNT_W'(1);
            end else if (do_pop && !do_push) begin
                cnt_q <= cnt_q - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q <= LVL_W'(LVL_RESET);
        end else if (lvl_wr) begin
            lvl_q <= lvl_data;
        end
    end

    rxq_storage #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (fifo_clr),
        .push      (do_push),
        .push_data (wr_data),
        .pop       (do_pop),
        .rd_zero   (do_zero),
        .rd_data   (rd_data)
    );

    rxq_idle_timer #(
        .TIME_W (TIME_W),
        .MULT   (TMO_CHARS)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (byte_seen),
        .char_time (char_time),
        .fire      (timeout_evt)
    );

    assign count       = cnt_q;
    assign empty       = is_empty;
    assign full        = is_full;
    assign trig_hit    = (CMP_W'(cnt_q) >= CMP_W'(lvl_q));
    assign overrun_evt = ovr_q;
endmodule

// File: rtl/uart_rx_queue_chk.sv
module uart_rx_queue_chk #(
    parameter int DEPTH = 16,
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_enable,
    input logic             fifo_clr,
    input logic             wr_en,
    input logic             rd_en,
    input logic [CNT_W-1:0] count,
    input logic             full,
    input logic             empty,
    input logic             overrun_evt,
    input logic             timeout_evt
);
    a_r3_ovr_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_evt |-> $past(full && wr_en && rx_enable && !fifo_clr));

    a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        int'(count) <= DEPTH);

    a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(fifo_clr) |-> (int'(count) - int'($past(count)) <= 1 &&
                              int'($past(count)) - int'(count) <= 1));

    a_r2_disabled_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(rx_enable) && !$past(fifo_clr)) |-> $stable(count));

    a_r9_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        $past(fifo_clr) |-> (count == '0 && empty && !full));

    a_r7_tmo_no_byte: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_evt |-> $past(!(wr_en && rx_enable)));

    a_r7_tmo_single: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_evt |=> !timeout_evt);
endmodule

bind uart_rx_queue uart_rx_queue_chk #(
    .DEPTH (DEPTH),
    .CNT_W ($clog2(DEPTH + 1))
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_enable   (rx_enable),
    .fifo_clr    (fifo_clr),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .count       (count),
    .full        (full),
    .empty       (empty),
    .overrun_evt (overrun_evt),
    .timeout_evt (timeout_evt)
);

// File: tb/uart_rx_queue_tb.sv
module uart_rx_queue_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_enable = 1'b0, fifo_clr = 1'b0, wr_en = 1'b0, rd_en = 1'b0, lvl_wr = 1'b0;
    logic [7:0] wr_data = '0;
    logic [5:0] lvl_data = '0;
    logic [15:0] char_time = 16'd1000;
    logic [7:0] rd_data;
    logic       empty, full, trig_hit, overrun_evt, timeout_evt;
    logic [4:0] count;

    int checks = 0;
    int errors = 0;
    logic [7:0] mq[$];
    logic [7:0] exp_rd = '0;
    int         exp_lvl = 32;
    logic       exp_ovr = 1'b0;
    logic [7:0] seed = 8'h5A;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_rx_queue u_dut (
        .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .fifo_clr(fifo_clr),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .lvl_wr(lvl_wr),
        .lvl_data(lvl_data), .char_time(char_time), .rd_data(rd_data),
        .empty(empty), .full(full), .trig_hit(trig_hit), .count(count),
        .overrun_evt(overrun_evt), .timeout_evt(timeout_evt)
    );

    task automatic chk(input string req, input logic ok, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic cmp_all(input string req);
        int n = mq.size();
        chk(req, count == 5'(n), "count", count, n);
        chk(req, empty == (n == 0), "empty", empty, n == 0);
        chk(req, full == (n == DEPTH), "full", full, n == DEPTH);
        chk(req, trig_hit == (n >= exp_lvl), "trig_hit", trig_hit, n >= exp_lvl);
        chk(req, overrun_evt == exp_ovr, "overrun_evt", overrun_evt, exp_ovr);
        chk(req, rd_data == exp_rd, "rd_data", rd_data, exp_rd);
    endtask

    // one cycle of stimulus; model serves the read from pre-cycle state first
    task automatic op(input logic w, input logic [7:0] d, input logic r,
                      input logic en, input logic clr, input string req);
        bit was_full;
        wr_en = w; wr_data = d; rd_en = r; rx_enable = en; fifo_clr = clr;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0; fifo_clr = 1'b0;
        exp_ovr = 1'b0;
        if (clr) begin
            mq.delete();
        end else if (en) begin
            was_full = (mq.size() == DEPTH);
            if (r) begin
                if (mq.size() > 0) exp_rd = mq.pop_front();
                else exp_rd = '0;
            end
            if (w) begin
                if (was_full) exp_ovr = 1'b1;
                else mq.push_back(d);
            end
        end
        cmp_all(req);
    endtask

    task automatic set_lvl(input int v);
        lvl_wr = 1'b1; lvl_data = 6'(v);
        @(negedge clk);
        lvl_wr = 1'b0;
        exp_lvl = v;
    endtask

    function automatic logic [7:0] nxt();
        seed = {seed[6:0], seed[7] ^ seed[5] ^ seed[4] ^ seed[3]};
        return seed;
    endfunction

    task automatic tmo_wait(input int n, input string req);
        for (int k = 1; k <= n + 1; k++) begin
            @(negedge clk);
            chk(req, timeout_evt == (k == n), "timeout_evt", timeout_evt, k == n);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        cmp_all("R1");
        chk("R1", timeout_evt == 1'b0, "timeout_evt", timeout_evt, 0);
        rst_n = 1'b1;
        @(negedge clk);
        cmp_all("R1");

        // R8: level resets to 32 -> full queue still does not trigger
        for (int i = 0; i < DEPTH; i++) op(1'b1, nxt(), 1'b0, 1'b1, 1'b0, "R8");
        chk("R8", trig_hit == 1'b0, "trig at reset level", trig_hit, 0);
        op(1'b0, 8'h00, 1'b0, 1'b1, 1'b1, "R9");

        // R4 R5 R3 R6 R8: sweep trigger levels, fill past full, drain past empty
        for (int lv = 0; lv <= 17; lv++) begin
            set_lvl(lv);
            for (int i = 0; i <= DEPTH; i++) op(1'b1, nxt(), 1'b0, 1'b1, 1'b0, "R4");
            for (int i = 0; i <= DEPTH; i++) op(1'b0, 8'h00, 1'b1, 1'b1, 1'b0, "R5");
        end

        // R2: disabled receiver ignores writes and reads
        set_lvl(3);
        op(1'b1, 8'hA1, 1'b0, 1'b1, 1'b0, "R2");
        op(1'b1, 8'hA2, 1'b0, 1'b1, 1'b0, "R2");
        op(1'b1, 8'hA3, 1'b0, 1'b0, 1'b0, "R2");
        op(1'b0, 8'h00, 1'b1, 1'b0, 1'b0, "R2");
        op(1'b1, 8'hA4, 1'b1, 1'b0, 1'b0, "R2");
        op(1'b0, 8'h00, 1'b1, 1'b1, 1'b0, "R2");
        op(1'b0, 8'h00, 1'b1, 1'b1, 1'b0, "R2");
        op(1'b0, 8'h00, 1'b1, 1'b1, 1'b0, "R6");

        // R10: write+read on empty, mid-fill, full
        op(1'b1, 8'h3C, 1'b1, 1'b1, 1'b0, "R10");
        op(1'b1, 8'h3D, 1'b1, 1'b1, 1'b0, "R10");
        for (int i = 0; i < DEPTH - 1; i++) op(1'b1, nxt(), 1'b0, 1'b1, 1'b0, "R10");
        op(1'b1, 8'hEE, 1'b1, 1'b1, 1'b0, "R10");
        op(1'b1, 8'hEF, 1'b0, 1'b1, 1'b0, "R3");
        op(1'b0, 8'h00, 1'b0, 1'b1, 1'b0, "R3");

        // R9: clear wins over simultaneous write and read
        op(1'b1, 8'h77, 1'b1, 1'b1, 1'b1, "R9");
        op(1'b1, 8'h78, 1'b0, 1'b1, 1'b0, "R9");
        op(1'b0, 8'h00, 1'b1, 1'b1, 1'b0, "R9");

        // R7: timeout after 4 character times, restart, zero char time
        char_time = 16'd3;
        op(1'b1, 8'h11, 1'b0, 1'b1, 1'b0, "R7");
        tmo_wait(12, "R7");
        repeat (20) begin
            @(negedge clk);
            chk("R7", timeout_evt == 1'b0, "idle after fire", timeout_evt, 0);
        end
        op(1'b1, 8'h12, 1'b0, 1'b1, 1'b0, "R7");
        repeat (6) @(negedge clk);
        op(1'b1, 8'h13, 1'b0, 1'b1, 1'b0, "R7");
        tmo_wait(12, "R7");
        char_time = 16'd0;
        op(1'b1, 8'h14, 1'b0, 1'b1, 1'b0, "R7");
        tmo_wait(1, "R7");
        op(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, "R7");
        chk("R7", timeout_evt == 1'b0, "no fire while disabled", timeout_evt, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule